// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the ordered column addresses for a single SDRAM burst. A controller presents a start column, a three-bit length code and a wrap-order select together with a one-cycle load strobe. From the next clock on the block emits one column per cycle on a registered output. A busy flag stays high while addresses are being emitted, and a final-beat flag marks the closing address of a fixed-length burst.

Bursts of 1, 2, 4 or 8 beats stay inside a block of columns aligned to the burst length. The offset inside that block either counts upward with wrap, or is formed by XOR of the start offset with the beat number. A whole-page burst counts upward through all columns of the page. It wraps at the page end and runs until a stop or a new load arrives. A new load during a burst abandons the rest of the old sequence and starts a complete new burst. The stop input ends the burst at once.

Top module: `burst_col_gen`

## Requirements
- R1: While rst_i is high, and after it is released with no load, busy_o and last_o are low.
- R2: A load accepted at a clock edge makes busy_o high and col_o equal to start_col_i in the following cycle. That cycle is beat 0.
- R3: With ilv_i=0 and a fixed length BL, beat k shows the column whose low log2(BL) bits are (start + k) mod BL. The upper bits are held from the start column.
- R4: With ilv_i=1 and a fixed length BL, beat k shows the start column with its low log2(BL) bits XORed with k. For BL 8 and start 2 the order is 2,3,0,1,6,7,4,5.
- R5: Length code 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. Code 7 selects whole-page. Codes 4, 5 and 6 give 1 beat.
- R6: last_o is high only on beat BL-1 of a fixed-length burst. busy_o is low in the cycle after that beat unless a new load was accepted.
- R7: In whole-page mode (code 7, ilv_i=0), each beat is the previous column plus one, modulo 512. The burst never raises last_o and continues until stop or load.
- R8: A load with ilv_i=1 and code 7 is ignored. A burst in progress continues unchanged, and an idle block stays idle.
- R9: A load accepted during a burst restarts the sequence from the new start column with the full new length. It may come on any cycle, including consecutive cycles.
- R10: stop_i without an accepted load makes busy_o and last_o low in the next cycle. When load and stop come together, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Start a new burst using the values below |
| start_col_i | input | 9 | First column of the burst |
| len_code_i | input | 3 | Burst length code (see R5) |
| ilv_i | input | 1 | Wrap order: 0 counting, 1 XOR |
| stop_i | input | 1 | End the current burst |
| col_o | output | 9 | Column address of the current beat |
| busy_o | output | 1 | A beat is being presented on col_o |
| last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The assertions assume that load_i, stop_i and the load fields are driven from the same clock domain and are stable around the sampling edge. They also assume that col_o has meaning only while busy_o is high. The checker therefore compares addresses only in busy cycles, and it records whether a whole-page burst was accepted by decoding the load fields itself. The stimulus drives every input just after a falling edge and holds it for the whole cycle. It covers each length code, both wrap orders, unaligned start columns, loads on back-to-back cycles and stop together with load, so the reference model sees every ordering in the requirements.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic {WRAP_SEQ = 1'b0, WRAP_XOR = 1'b1} wrap_e;

  typedef struct packed {
    logic ok;
    logic page;
  } len_flags_t;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
  parameter int COL_W     = 9,
  parameter int CODE_W    = 3,
  parameter int MAX_LOG   = 3,
  parameter int PAGE_CODE = 7
) (
  input  logic [CODE_W-1:0]  code_i,
  input  bcg_pkg::wrap_e     wrap_i,
  output logic [COL_W-1:0]   mask_o,
  output bcg_pkg::len_flags_t flags_o
);
  localparam logic [CODE_W-1:0] PAGE_C = CODE_W'(PAGE_CODE);
  localparam logic [CODE_W-1:0] MAXL_C = CODE_W'(MAX_LOG);

  logic [COL_W:0] one_sh;

  always_comb begin
    one_sh       = '0;
    mask_o       = '0;
    flags_o.page = 1'b0;
    if (code_i == PAGE_C) begin
      mask_o       = '1;
      flags_o.page = 1'b1;
    end else if (code_i <= MAXL_C) begin
      one_sh = {{COL_W{1'b0}}, 1'b1} << code_i;
      mask_o = one_sh[COL_W-1:0] - 1'b1;
    end
    flags_o.ok = !(flags_o.page && (wrap_i == bcg_pkg::WRAP_XOR));
  end
endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr #(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             page_i,
  output logic [COL_W-1:0] cnt_nxt_o,
  output logic             adv_o,
  output logic             busy_q,
  output logic             last_q
);
  logic [COL_W-1:0] cnt_q;
  logic [COL_W-1:0] cnt_inc;

  assign cnt_inc   = cnt_q + 1'b1;
  assign cnt_nxt_o = start_i ? '0 : cnt_inc;
  assign adv_o     = start_i || (busy_q && !last_q && !stop_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      last_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
      last_q <= !page_i && (mask_i == '0);
    end else if (stop_i) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
    end else if (busy_q) begin
      if (last_q) begin
        busy_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_inc;
        last_q <= !page_i && (cnt_inc == mask_i);
      end
    end
  end
endmodule

// File: rtl/bcg_addr_form.sv
module bcg_addr_form #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  bcg_pkg::wrap_e   wrap_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] off_sum;
  logic [COL_W-1:0] off_xor;
  logic [COL_W-1:0] off_sel;

  assign off_sum = base_i + beat_i;
  assign off_xor = base_i ^ beat_i;
  assign off_sel = (wrap_i == bcg_pkg::WRAP_XOR) ? off_xor : off_sum;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? off_sel[b] : base_i[b];
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W     = 9,
  parameter int CODE_W    = 3,
  parameter int MAX_LOG   = 3,
  parameter int PAGE_CODE = 7
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              ilv_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              busy_o,
  output logic              last_o
);
  import bcg_pkg::*;

  wrap_e            wrap_in;
  logic [COL_W-1:0] dec_mask;
  len_flags_t       dec_flags;
  logic             take;

  logic [COL_W-1:0] base_q, mask_q;
  wrap_e            wrap_q;
  logic             page_q;

  logic [COL_W-1:0] base_sel, mask_sel;
  wrap_e            wrap_sel;
  logic             page_sel;

  logic [COL_W-1:0] beat_nxt;
  logic             adv;
  logic [COL_W-1:0] col_nxt;

  assign wrap_in = wrap_e'(ilv_i);

  bcg_len_decode #(
    .COL_W(COL_W), .CODE_W(CODE_W), .MAX_LOG(MAX_LOG), .PAGE_CODE(PAGE_CODE)
  ) u_dec (
    .code_i (len_code_i),
    .wrap_i (wrap_in),
    .mask_o (dec_mask),
    .flags_o(dec_flags)
  );

  assign take = load_i && dec_flags.ok;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      base_q <= '0;
      mask_q <= '0;
      wrap_q <= WRAP_SEQ;
      page_q <= 1'b0;
    end else if (take) begin
      base_q <= start_col_i;
      mask_q <= dec_mask;
      wrap_q <= wrap_in;
      page_q <= dec_flags.page;
    end
  end

  assign base_sel = take ? start_col_i    : base_q;
  assign mask_sel = take ? dec_mask       : mask_q;
  assign wrap_sel = take ? wrap_in        : wrap_q;
  assign page_sel = take ? dec_flags.page : page_q;

  bcg_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .start_i  (take),
    .stop_i   (stop_i),
    .mask_i   (mask_sel),
    .page_i   (page_sel),
    .cnt_nxt_o(beat_nxt),
    .adv_o    (adv),
    .busy_q   (busy_o),
    .last_q   (last_o)
  );

  bcg_addr_form #(.COL_W(COL_W)) u_form (
    .base_i(base_sel),
    .beat_i(beat_nxt),
    .mask_i(mask_sel),
    .wrap_i(wrap_sel),
    .col_o (col_nxt)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      col_o <= '0;
    end else if (adv) begin
      col_o <= col_nxt;
    end
  end
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int COL_W     = 9,
  parameter int CODE_W    = 3,
  parameter int PAGE_CODE = 7
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              load_i,
  input logic [COL_W-1:0]  start_col_i,
  input logic [CODE_W-1:0] len_code_i,
  input logic              ilv_i,
  input logic              stop_i,
  input logic [COL_W-1:0]  col_o,
  input logic              busy_o,
  input logic              last_o
);
  logic             acc;
  logic             pg_seen;
  logic [COL_W-1:0] inc_q;

  assign acc = load_i && !(ilv_i && (len_code_i == CODE_W'(PAGE_CODE)));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pg_seen <= 1'b0;
      inc_q   <= '0;
    end else begin
      if (acc) pg_seen <= (len_code_i == CODE_W'(PAGE_CODE));
      inc_q <= col_o + 1'b1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk_i) rst_i |=> !busy_o && !last_o); // R1
  AST_LOAD_START: assert property (@(posedge clk_i) disable iff (rst_i)
    acc |=> busy_o && (col_o == $past(start_col_i))); // R2
  AST_LAST_IN_BURST: assert property (@(posedge clk_i) disable iff (rst_i)
    last_o |-> busy_o); // R6
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (rst_i)
    last_o && !acc |=> !busy_o); // R6
  AST_PAGE_NO_LAST: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o && pg_seen |-> !last_o); // R7
  AST_PAGE_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o && pg_seen && !acc && !stop_i |=> busy_o && (col_o == inc_q)); // R7
  AST_STOP_ENDS: assert property (@(posedge clk_i) disable iff (rst_i)
    stop_i && !acc |=> !busy_o && !last_o); // R10
  AST_REJECT_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i && !acc && !busy_o && !stop_i |=> !busy_o); // R8
endmodule

bind burst_col_gen bcg_checker #(
  .COL_W(COL_W), .CODE_W(CODE_W), .PAGE_CODE(PAGE_CODE)
) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .load_i     (load_i),
  .start_col_i(start_col_i),
  .len_code_i (len_code_i),
  .ilv_i      (ilv_i),
  .stop_i     (stop_i),
  .col_o      (col_o),
  .busy_o     (busy_o),
  .last_o     (last_o)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
  localparam int CW = 9;
  localparam int PAGE = 512;

  logic          clk = 1'b0;
  logic          rst;
  logic          load;
  logic [CW-1:0] start;
  logic [2:0]    code;
  logic          ilv;
  logic          stop;
  logic [CW-1:0] col;
  logic          busy;
  logic          last;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_busy = 0, m_start = 0, m_len = 1, m_ilv = 0, m_k = 0;

  always #2.5 clk = ~clk;

  burst_col_gen u0 (
    .clk_i(clk), .rst_i(rst), .load_i(load), .start_col_i(start),
    .len_code_i(code), .ilv_i(ilv), .stop_i(stop),
    .col_o(col), .busy_o(busy), .last_o(last)
  );

  function automatic int len_of(input int c);
    case (c)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col();
    int blk, off;
    if (m_len == 0) return (m_start + m_k) % PAGE;
    blk = m_start - (m_start % m_len);
    if (m_ilv != 0) off = (m_start % m_len) ^ m_k;
    else            off = ((m_start % m_len) + m_k) % m_len;
    return blk + off;
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit ld, input int st, input int cd, input bit il,
                      input bit sp, input string tag);
    int el;
    load = ld; start = CW'(st); code = 3'(cd); ilv = il; stop = sp;
    @(posedge clk);
    if (ld && !(il && cd == 7)) begin
      m_busy = 1; m_k = 0; m_start = st; m_len = len_of(cd); m_ilv = il;
    end else if (sp) begin
      m_busy = 0;
    end else if (m_busy != 0) begin
      if (m_len != 0 && m_k == m_len - 1) m_busy = 0;
      else m_k++;
    end
    @(negedge clk);
    el = (m_busy != 0 && m_len != 0 && m_k == m_len - 1) ? 1 : 0;
    chk(tag, int'(busy), m_busy, "busy");
    chk(tag, int'(last), el, "last");
    if (m_busy != 0) chk(tag, int'(col), exp_col(), "col");
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; load = 0; start = '0; code = '0; ilv = 0; stop = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(busy), 0, "busy in reset");
    chk("R1", int'(last), 0, "last in reset");
    rst = 0;
    idle(2, "R1");

    // R2 R3: counting BL4 from unaligned start 5 -> 5,6,7,4
    step(1, 5, 2, 0, 0, "R2");
    idle(5, "R3");
    // R3: BL8 from 13 -> stays in block 8..15
    step(1, 13, 3, 0, 0, "R3");
    idle(9, "R3");
    // R4: XOR BL8 from 2 -> 2,3,0,1,6,7,4,5
    step(1, 2, 3, 1, 0, "R4");
    idle(9, "R4");
    // R4: XOR BL4 from 7
    step(1, 7, 2, 1, 0, "R4");
    idle(5, "R4");
    // R5: codes 0,1,4,5,6
    step(1, 100, 0, 0, 0, "R5");
    idle(2, "R5");
    step(1, 101, 1, 0, 0, "R5");
    idle(3, "R5");
    step(1, 33, 4, 0, 0, "R5");
    idle(2, "R5");
    step(1, 34, 5, 1, 0, "R5");
    idle(2, "R5");
    step(1, 35, 6, 0, 0, "R5");
    idle(2, "R5");
    // R6: last then load in last cycle keeps busy
    step(1, 16, 1, 0, 0, "R6");
    step(0, 0, 0, 0, 0, "R6");
    step(1, 40, 1, 1, 0, "R6");
    idle(3, "R6");
    // R7: page burst wraps 511 -> 0, then stop
    step(1, 508, 7, 0, 0, "R7");
    idle(12, "R7");
    step(0, 0, 0, 0, 1, "R10");
    idle(2, "R10");
    // R8: rejected load during a burst and while idle
    step(1, 48, 3, 0, 0, "R8");
    idle(2, "R8");
    step(1, 200, 7, 1, 0, "R8");
    idle(6, "R8");
    step(1, 300, 7, 1, 0, "R8");
    idle(2, "R8");
    // R9: restarts mid-burst and on back-to-back cycles
    step(1, 64, 3, 0, 0, "R9");
    idle(2, "R9");
    step(1, 130, 3, 1, 0, "R9");
    step(1, 255, 2, 0, 0, "R9");
    step(1, 6, 1, 1, 0, "R9");
    step(1, 3, 3, 0, 0, "R9");
    idle(9, "R9");
    // R10: stop mid-burst, stop with load, stop while idle
    step(1, 80, 3, 0, 0, "R10");
    idle(2, "R10");
    step(0, 0, 0, 0, 1, "R10");
    idle(2, "R10");
    step(1, 90, 2, 0, 0, "R10");
    step(1, 20, 2, 1, 1, "R10");
    idle(5, "R10");
    step(0, 0, 0, 0, 1, "R10");
    idle(2, "R1");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule